// File: doc/BRIEF.md
# Script Engine Start Controller

This block decides when an instruction-fetching script engine begins work and when it stops. It holds the script pointer and a small set of control bits: a self-clearing start strobe, an interrupt mask, an output-driver style select and a compatibility flag that survives a software reset. It also holds two mode bits, manual-start and single-step. When the engine may run, the block raises a one-cycle fetch request that carries the current pointer. The engine answers with a completion pulse, and that pulse may flag an interrupt.

The modes set when fetching starts. With both mode bits clear, writing the pointer starts fetching at once. In manual-start mode, a pointer write only loads the address, and a start strobe is needed. After that strobe the engine keeps fetching until an interrupt stops it. In single-step mode, the engine halts after every instruction and raises a step interrupt. Each further instruction needs a new start strobe. The pending interrupt drives an active-low pin, either as open-drain or driven both ways. An acknowledge input clears it. While the engine runs, only the engine itself may access the registers. Host writes are dropped and host reads return zero.

Top module: `scr_start_ctrl`

## Requirements
- R1: Writing 1 to control bit 2 while idle makes that bit read 1 in the next cycle and 0 afterwards. In the cycle after that, fetch_req is high for exactly one cycle with fetch_addr equal to the pointer.
- R2: With mode register bit 0 set (manual start), a pointer write loads the address but raises no fetch_req until a start strobe arrives.
- R3: Unless single-step is on, a completion without the interrupt flag gives a new fetch_req in the very next cycle at the old address plus INSTR_BYTES. No start strobe is needed.
- R4: With step register bit 4 set, every completion halts the engine and sets the pending interrupt. The next fetch happens only after a new start strobe, at the advanced address.
- R5: A completion with instr_int set halts the engine in any mode and sets the pending interrupt. The pointer still advances by INSTR_BYTES.
- R6: irq_ack clears the pending interrupt. The engine stays halted afterwards.
- R7: Control bit 1 set forces the interrupt pin inactive, whatever is pending. Clearing it restores normal signalling.
- R8: Control bit 3 selects the pin driver. When it is 1, irq_pin_oe is always 1 and irq_pin is low exactly while the interrupt is active. When it is 0, irq_pin is always 0 and irq_pin_oe is 1 exactly while the interrupt is active.
- R9: soft_rst clears control bits 1 to 3, the mode and step bits and the pending interrupt, and returns the engine to idle. Control bit 0 and the pointer keep their values.
- R10: While engine_busy is high, host writes are ignored and host reads return 0. Accesses flagged as coming from the engine still read and write normally.
- R11: With both mode bits clear, a pointer write starts fetching without a strobe. fetch_req comes one cycle after the write takes effect, at the new address.
- R12: After rst, every register reads 0, fetch_req is low and the pin is released. Field positions for read back are: control bits 0 to 3, mode bit 0, step bit 4 and the whole pointer. The register addresses are 0 control, 1 mode, 2 step, 3 pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Software reset; keeps the compatibility bit and pointer |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address (0 control, 1 mode, 2 step, 3 pointer) |
| reg_wr_data | input | DATA_W | Write data |
| reg_wr_by_engine | input | 1 | Write comes from the script engine |
| reg_rd_addr | input | 2 | Read address |
| reg_rd_by_engine | input | 1 | Read comes from the script engine |
| reg_rd_data | output | DATA_W | Read data (combinational) |
| instr_done | input | 1 | Engine completed the fetched instruction |
| instr_int | input | 1 | The completed instruction raised an interrupt |
| irq_ack | input | 1 | Acknowledge, clears the pending interrupt |
| fetch_req | output | 1 | One-cycle fetch request |
| fetch_addr | output | PTR_W | Address to fetch |
| engine_busy | output | 1 | Engine is executing (fetching or awaiting completion) |
| irq_pin | output | 1 | Active-low interrupt pin value |
| irq_pin_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest state to reach is an interrupt that is pending while the engine has halted, combined with each driver style and with the mask. A halt comes only through the completion handshake, so the stimulus first starts the engine, waits for the fetch request and answers it with a flagged completion. Only then does it flip the mask and driver bits and watch both pin outputs. The lockout during execution is just as indirect. Host writes are issued in the cycles between the fetch request and the completion. Their effect is then read back through an engine-side access.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 2'd0,
        RA_MODE = 2'd1,
        RA_STEP = 2'd2,
        RA_PTR  = 2'd3
    } reg_addr_e;

    localparam int CTRL_W       = 4;
    localparam int CTRL_COMPAT  = 0;
    localparam int CTRL_IRQ_DIS = 1;
    localparam int CTRL_START   = 2;
    localparam int CTRL_DRIVE   = 3;
    localparam int MODE_MANUAL  = 0;
    localparam int STEP_ENABLE  = 4;

    // packed MSB first: bit3 drive, bit2 start, bit1 mask, bit0 compat
    typedef struct packed {
        logic drive_both;
        logic start;
        logic irq_dis;
        logic compat;
    } ctrl_t;

    typedef struct packed {
        logic manual;
        logic step;
    } mode_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    function automatic logic access_ok(input logic by_engine, input logic busy);
        return by_engine || !busy;
    endfunction

    function automatic logic free_running(input mode_t m);
        return !m.manual && !m.step;
    endfunction

endpackage

// File: rtl/scr_regs.sv
`timescale 1ns/1ps
module scr_regs
    import scr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PTR_W       = 32,
    parameter int INSTR_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    soft_rst,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    wr_eng,
    input  logic [REG_AW-1:0]       rd_addr,
    input  logic                    rd_eng,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    busy,
    input  logic                    ptr_inc,
    output logic                    start_o,
    output logic                    irq_dis_o,
    output logic                    drive_both_o,
    output mode_t                   mode_o,
    output logic [PTR_W-1:0]        ptr_o,
    output logic                    ptr_wr_o
);

    localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(INSTR_BYTES);

    ctrl_t            ctrl_q;
    mode_t            mode_q;
    logic [PTR_W-1:0] ptr_q;
    logic             ptr_wr_q;
    logic [DATA_W-1:0] ptr_rd;

    reg_addr_e wa;
    reg_addr_e ra;
    logic      wr_ok;
    logic      start_wr;

    assign wa       = reg_addr_e'(wr_addr);
    assign ra       = reg_addr_e'(rd_addr);
    assign wr_ok    = wr_en && access_ok(wr_eng, busy);
    assign start_wr = wr_ok && (wa == RA_CTRL) && wr_data[CTRL_START];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            mode_q   <= '0;
            ptr_q    <= '0;
            ptr_wr_q <= 1'b0;
        end else if (soft_rst) begin
            ctrl_q.drive_both <= 1'b0;
            ctrl_q.start      <= 1'b0;
            ctrl_q.irq_dis    <= 1'b0;
            mode_q            <= '0;
            ptr_wr_q          <= 1'b0;
        end else begin
            ctrl_q.start <= start_wr;
            ptr_wr_q     <= wr_ok && (wa == RA_PTR);
            if (wr_ok) begin
                unique case (wa)
                    RA_CTRL: begin
                        ctrl_q.compat     <= wr_data[CTRL_COMPAT];
                        ctrl_q.irq_dis    <= wr_data[CTRL_IRQ_DIS];
                        ctrl_q.drive_both <= wr_data[CTRL_DRIVE];
                    end
                    RA_MODE: mode_q.manual <= wr_data[MODE_MANUAL];
                    RA_STEP: mode_q.step   <= wr_data[STEP_ENABLE];
                    RA_PTR:  ptr_q         <= wr_data[PTR_W-1:0];
                    default: ;
                endcase
            end
            if (ptr_inc && !(wr_ok && wa == RA_PTR)) begin
                ptr_q <= ptr_q + PTR_STEP;
            end
        end
    end

    generate
        if (PTR_W < DATA_W) begin : g_ptr_ext
            assign ptr_rd = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
        end else begin : g_ptr_full
            assign ptr_rd = ptr_q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (access_ok(rd_eng, busy)) begin
            unique case (ra)
                RA_CTRL: rd_data[CTRL_W-1:0]  = ctrl_q;
                RA_MODE: rd_data[MODE_MANUAL] = mode_q.manual;
                RA_STEP: rd_data[STEP_ENABLE] = mode_q.step;
                RA_PTR:  rd_data              = ptr_rd;
                default: rd_data              = '0;
            endcase
        end
    end

    assign start_o      = ctrl_q.start;
    assign irq_dis_o    = ctrl_q.irq_dis;
    assign drive_both_o = ctrl_q.drive_both;
    assign mode_o       = mode_q;
    assign ptr_o        = ptr_q;
    assign ptr_wr_o     = ptr_wr_q;

    AST_START_SELFCLR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.start && !start_wr) |=> !ctrl_q.start); // R1

    AST_HOST_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_eng && busy && !soft_rst) |=>
        (ctrl_q.compat == $past(ctrl_q.compat) && ctrl_q.irq_dis == $past(ctrl_q.irq_dis)
         && ctrl_q.drive_both == $past(ctrl_q.drive_both) && mode_q == $past(mode_q))); // R10

    AST_COMPAT_KEEP: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl_q.compat == $past(ctrl_q.compat) && mode_q == '0
                      && !ctrl_q.irq_dis && !ctrl_q.drive_both)); // R9

endmodule

// File: rtl/scr_seq.sv
`timescale 1ns/1ps
module scr_seq
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst,
    input  logic  start,
    input  logic  ptr_wr,
    input  mode_t mode,
    input  logic  instr_done,
    input  logic  instr_int,
    output logic  fetch_req,
    output logic  busy,
    output logic  ptr_inc,
    output logic  step_set,
    output logic  int_set
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d  = state_q;
        ptr_inc  = 1'b0;
        step_set = 1'b0;
        int_set  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start || (ptr_wr && free_running(mode))) begin
                    state_d = SQ_FETCH;
                end
            end
            SQ_FETCH: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (instr_done) begin
                    ptr_inc = 1'b1;
                    if (instr_int) begin
                        int_set = 1'b1;
                        state_d = SQ_IDLE;
                    end else if (mode.step) begin
                        step_set = 1'b1;
                        state_d  = SQ_IDLE;
                    end else begin
                        state_d = SQ_FETCH;
                    end
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_req = (state_q == SQ_FETCH);
    assign busy      = (state_q != SQ_IDLE);

    AST_FETCH_ONE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req); // R1

    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && ptr_wr && mode.manual && !start) |=> !fetch_req); // R2

    AST_STEP_HALT: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT && instr_done && mode.step && !soft_rst) |=> !busy); // R4

    AST_RUN_ON: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT && instr_done && !instr_int && !mode.step && !soft_rst) |=> fetch_req); // R3

endmodule

// File: rtl/scr_irq.sv
`timescale 1ns/1ps
module scr_irq (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic step_set,
    input  logic int_set,
    input  logic irq_ack,
    input  logic irq_dis,
    input  logic drive_both,
    output logic pin,
    output logic pin_oe
);

    logic pending_q;
    logic active;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            pending_q <= 1'b0;
        end else if (step_set || int_set) begin
            pending_q <= 1'b1;
        end else if (irq_ack) begin
            pending_q <= 1'b0;
        end
    end

    assign active = pending_q && !irq_dis;

    always_comb begin
        if (drive_both) begin
            pin_oe = 1'b1;
            pin    = !active;
        end else begin
            pin_oe = active;
            pin    = 1'b0;
        end
    end

    AST_SET_PEND: assert property (@(posedge clk) disable iff (rst)
        ((step_set || int_set) && !soft_rst) |=> pending_q); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !step_set && !int_set) |=> !pending_q); // R6

    AST_MASKED: assert property (@(posedge clk) disable iff (rst)
        irq_dis |-> (!pin_oe || pin)); // R7

    AST_OD_LOW: assert property (@(posedge clk) disable iff (rst)
        !drive_both |-> !pin); // R8

endmodule

// File: rtl/scr_start_ctrl.sv
`timescale 1ns/1ps
module scr_start_ctrl
    import scr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PTR_W       = 32,
    parameter int INSTR_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_wr_by_engine,
    input  logic [1:0]        reg_rd_addr,
    input  logic              reg_rd_by_engine,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              instr_done,
    input  logic              instr_int,
    input  logic              irq_ack,
    output logic              fetch_req,
    output logic [PTR_W-1:0]  fetch_addr,
    output logic              engine_busy,
    output logic              irq_pin,
    output logic              irq_pin_oe
);

    logic  start_w;
    logic  irq_dis_w;
    logic  drive_w;
    mode_t mode_w;
    logic  ptr_wr_w;
    logic  ptr_inc_w;
    logic  step_set_w;
    logic  int_set_w;
    logic  busy_w;

    scr_regs #(
        .DATA_W      (DATA_W),
        .PTR_W       (PTR_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) regs_i (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .wr_en        (reg_wr_en),
        .wr_addr      (reg_wr_addr),
        .wr_data      (reg_wr_data),
        .wr_eng       (reg_wr_by_engine),
        .rd_addr      (reg_rd_addr),
        .rd_eng       (reg_rd_by_engine),
        .rd_data      (reg_rd_data),
        .busy         (busy_w),
        .ptr_inc      (ptr_inc_w),
        .start_o      (start_w),
        .irq_dis_o    (irq_dis_w),
        .drive_both_o (drive_w),
        .mode_o       (mode_w),
        .ptr_o        (fetch_addr),
        .ptr_wr_o     (ptr_wr_w)
    );

    scr_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .start      (start_w),
        .ptr_wr     (ptr_wr_w),
        .mode       (mode_w),
        .instr_done (instr_done),
        .instr_int  (instr_int),
        .fetch_req  (fetch_req),
        .busy       (busy_w),
        .ptr_inc    (ptr_inc_w),
        .step_set   (step_set_w),
        .int_set    (int_set_w)
    );

    scr_irq irq_i (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .step_set   (step_set_w),
        .int_set    (int_set_w),
        .irq_ack    (irq_ack),
        .irq_dis    (irq_dis_w),
        .drive_both (drive_w),
        .pin        (irq_pin),
        .pin_oe     (irq_pin_oe)
    );

    assign engine_busy = busy_w;

endmodule

// File: tb/scr_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module scr_start_ctrl_tb_top;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MODE = 2'd1;
    localparam logic [1:0] A_STEP = 2'd2;
    localparam logic [1:0] A_PTR  = 2'd3;

    // {address, write data, expected host read back}
    localparam logic [65:0] VEC [8] = '{
        {A_CTRL, 32'h0000_00F3, 32'h0000_0003},
        {A_CTRL, 32'h0000_000A, 32'h0000_000A},
        {A_CTRL, 32'h0000_0000, 32'h0000_0000},
        {A_MODE, 32'hFFFF_FFFF, 32'h0000_0001},
        {A_PTR,  32'h0000_0120, 32'h0000_0120},
        {A_STEP, 32'hFFFF_FFFE, 32'h0000_0010},
        {A_STEP, 32'h0000_0000, 32'h0000_0000},
        {A_MODE, 32'h0000_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_wr_by_engine = 1'b0;
    logic [1:0]  reg_rd_addr = '0;
    logic        reg_rd_by_engine = 1'b0;
    logic [31:0] reg_rd_data;
    logic        instr_done = 1'b0;
    logic        instr_int = 1'b0;
    logic        irq_ack = 1'b0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        engine_busy;
    logic        irq_pin;
    logic        irq_pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rdv;

    always #2.5 clk = ~clk;

    scr_start_ctrl dut_i (
        .clk              (clk),
        .rst              (rst),
        .soft_rst         (soft_rst),
        .reg_wr_en        (reg_wr_en),
        .reg_wr_addr      (reg_wr_addr),
        .reg_wr_data      (reg_wr_data),
        .reg_wr_by_engine (reg_wr_by_engine),
        .reg_rd_addr      (reg_rd_addr),
        .reg_rd_by_engine (reg_rd_by_engine),
        .reg_rd_data      (reg_rd_data),
        .instr_done       (instr_done),
        .instr_int        (instr_int),
        .irq_ack          (irq_ack),
        .fetch_req        (fetch_req),
        .fetch_addr       (fetch_addr),
        .engine_busy      (engine_busy),
        .irq_pin          (irq_pin),
        .irq_pin_oe       (irq_pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d, input logic eng);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d; reg_wr_by_engine = eng;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_by_engine = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic eng, output logic [31:0] d);
        reg_rd_addr = a; reg_rd_by_engine = eng;
        #0.5;
        d = reg_rd_data;
    endtask

    // called at the negedge where fetch_req is high
    task automatic finish_instr(input logic with_int);
        @(negedge clk);
        instr_done = 1'b1; instr_int = with_int;
        @(negedge clk);
        instr_done = 1'b0; instr_int = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic fetch_check(input string req, input logic [31:0] addr);
        chk({req, " fetch_req"}, {31'b0, fetch_req}, 32'd1);
        chk({req, " fetch_addr"}, fetch_addr, addr);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int idle_hits;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 fetch_req after reset", {31'b0, fetch_req}, 32'd0);
        chk("R12 pin released", {31'b0, irq_pin_oe}, 32'd0);
        reg_read(A_CTRL, 1'b0, rdv); chk("R12 ctrl reset", rdv, 32'd0);
        reg_read(A_PTR, 1'b0, rdv);  chk("R12 ptr reset", rdv, 32'd0);

        // R12 field positions via vector table
        for (int i = 0; i < 8; i++) begin
            reg_write(VEC[i][65:64], VEC[i][63:32], 1'b0);
            reg_read(VEC[i][65:64], 1'b0, rdv);
            chk("R12 readback vector", rdv, VEC[i][31:0]);
            chk("R2 no fetch during table", {31'b0, fetch_req}, 32'd0);
        end

        // R11 automatic start on pointer write
        reg_write(A_CTRL, 32'h1, 1'b0);
        reg_write(A_PTR, 32'h40, 1'b0);
        chk("R11 not yet fetching", {31'b0, fetch_req}, 32'd0);
        @(negedge clk);
        fetch_check("R11", 32'h40);
        chk("R10 busy flag", {31'b0, engine_busy}, 32'd1);
        reg_read(A_CTRL, 1'b0, rdv); chk("R10 host read zero", rdv, 32'd0);
        reg_read(A_CTRL, 1'b1, rdv); chk("R10 engine read", rdv, 32'd1);
        reg_write(A_CTRL, 32'h2, 1'b0);
        reg_read(A_CTRL, 1'b1, rdv); chk("R10 host write ignored", rdv, 32'd1);
        reg_write(A_CTRL, 32'h3, 1'b1);
        reg_read(A_CTRL, 1'b1, rdv); chk("R10 engine write", rdv, 32'd3);
        reg_write(A_CTRL, 32'h1, 1'b1);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        fetch_check("R3 auto continue", 32'h48);
        finish_instr(1'b1);
        chk("R5 halted", {31'b0, engine_busy}, 32'd0);
        chk("R8 open-drain asserted oe", {31'b0, irq_pin_oe}, 32'd1);
        chk("R8 open-drain low", {31'b0, irq_pin}, 32'd0);
        ack_pulse();
        chk("R6 ack releases pin", {31'b0, irq_pin_oe}, 32'd0);
        idle_hits = 0;
        for (int i = 0; i < 3; i++) begin
            if (fetch_req) idle_hits++;
            @(negedge clk);
        end
        chk("R6 stays halted", idle_hits, 0);

        // R1 start strobe, R5 pointer advanced, R8 totem, R7 mask
        reg_write(A_CTRL, 32'h9, 1'b0);
        reg_write(A_CTRL, 32'hD, 1'b0);
        reg_read(A_CTRL, 1'b0, rdv); chk("R1 start reads one", rdv, 32'hD);
        @(negedge clk);
        fetch_check("R1 R5", 32'h50);
        reg_read(A_CTRL, 1'b1, rdv); chk("R1 start self-clears", rdv, 32'h9);
        finish_instr(1'b1);
        chk("R8 totem active low", {31'b0, irq_pin}, 32'd0);
        chk("R8 totem oe", {31'b0, irq_pin_oe}, 32'd1);
        reg_write(A_CTRL, 32'hB, 1'b0);
        chk("R7 masked pin high", {31'b0, irq_pin}, 32'd1);
        reg_write(A_CTRL, 32'h9, 1'b0);
        chk("R7 unmasked pin low", {31'b0, irq_pin}, 32'd0);
        ack_pulse();
        chk("R8 totem inactive high", {31'b0, irq_pin}, 32'd1);
        chk("R8 totem oe idle", {31'b0, irq_pin_oe}, 32'd1);

        // R2 manual start, R3 continuous after one strobe
        reg_write(A_MODE, 32'h1, 1'b0);
        reg_write(A_PTR, 32'h200, 1'b0);
        idle_hits = 0;
        for (int i = 0; i < 4; i++) begin
            if (fetch_req) idle_hits++;
            @(negedge clk);
        end
        chk("R2 manual holds", idle_hits, 0);
        reg_write(A_CTRL, 32'hD, 1'b0);
        @(negedge clk);
        fetch_check("R2 R1 manual start", 32'h200);
        finish_instr(1'b0);
        fetch_check("R3 manual continue", 32'h208);
        finish_instr(1'b1);
        ack_pulse();

        // R4 single step
        reg_write(A_MODE, 32'h0, 1'b0);
        reg_write(A_STEP, 32'h10, 1'b0);
        reg_write(A_CTRL, 32'hD, 1'b0);
        @(negedge clk);
        fetch_check("R4 step first", 32'h210);
        finish_instr(1'b0);
        chk("R4 step halts", {31'b0, engine_busy}, 32'd0);
        chk("R4 step irq pin", {31'b0, irq_pin}, 32'd0);
        idle_hits = 0;
        for (int i = 0; i < 3; i++) begin
            if (fetch_req) idle_hits++;
            @(negedge clk);
        end
        chk("R4 waits for strobe", idle_hits, 0);
        reg_write(A_CTRL, 32'hD, 1'b0);
        @(negedge clk);
        fetch_check("R4 step resume", 32'h218);
        finish_instr(1'b0);
        ack_pulse();

        // R9 soft reset
        reg_write(A_CTRL, 32'hB, 1'b0);
        reg_write(A_MODE, 32'h1, 1'b0);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        reg_read(A_CTRL, 1'b0, rdv); chk("R9 compat kept", rdv, 32'h1);
        reg_read(A_MODE, 1'b0, rdv); chk("R9 mode cleared", rdv, 32'h0);
        reg_read(A_STEP, 1'b0, rdv); chk("R9 step cleared", rdv, 32'h0);
        reg_read(A_PTR, 1'b0, rdv);  chk("R9 pointer kept", rdv, 32'h220);

        // R12 hard reset clears compat
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reg_read(A_CTRL, 1'b0, rdv); chk("R12 hard reset ctrl", rdv, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule